// File: doc/BRIEF.md
# Row-Ordered Delta Hit Encoder

This block sits between the column readout of a pixel matrix and a set of entropy coders. During an event, pixel hits arrive one at a time, each tagged with its column, its row and an ADC amplitude. Every hit is stored in the queue of its own column, so the column index is carried by the choice of queue. When the event is closed, the block copies every stored hit into the queue of its row. The column queues are emptied one after another, starting at column 0. It then reads the row queues, lowest row first, and emits one tuple per hit on a valid/ready stream.

Each tuple carries the signed step in row coordinate, the signed step in column coordinate, and the hit's ADC value. Both steps are measured from the previous hit of the same event. The first hit of an event is measured from the origin. Walking the hits in row-major order keeps the coordinate steps small and concentrated, which is what the three downstream coders (row step, column step, amplitude) exploit. While the block is busy with an event it refuses new hits. A row queue that fills up loses the extra hit and raises a flag that stays set.

Top module: `rowdelta_encoder`

## Requirements
- R1: After reset, `out_valid` is 0, `hit_ready` is 1 and `ovf_err` is 0.
- R2: A hit is taken only when `hit_valid` and `hit_ready` are both 1. `hit_ready` is 1 only while the block is collecting and the addressed column queue holds fewer than CDEPTH hits. A hit presented while `hit_ready` is 0 never shows up at the output.
- R3: Within one event, tuples come out ordered by ascending row, then by ascending column. Hits at the same row and column keep their arrival order. Every stored hit that is not dropped comes out once.
- R4: A tuple holds `out_dx` = row(n) − row(n−1) and `out_dy` = col(n) − col(n−1), each in two's complement one bit wider than its coordinate, plus the ADC value of hit n unchanged.
- R5: The first tuple of every event measures its steps from row 0, column 0, whatever the previous event ended on.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and all tuple fields hold their values into the next cycle.
- R7: Hits are copied into the row queues column by column, from column 0 upward, in arrival order within a column. A hit that finds its row queue already holding RDEPTH hits is discarded and sets `ovf_err`. `ovf_err` stays 1 until reset.
- R8: No tuple is presented while hits are being collected. Output starts only after `event_end` and after every column queue is empty. An event with no hits produces no tuple, and the block goes back to accepting hits.
- R9: An `event_end` pulse that arrives while an event is still being processed is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hit_valid | input | 1 | A hit is offered |
| hit_col | input | YW ($clog2(NCOL)) | Column index of the hit |
| hit_row | input | XW ($clog2(NROW)) | Row index of the hit, below NROW |
| hit_adc | input | ADCW | Amplitude of the hit |
| hit_ready | output | 1 | The hit is taken this cycle if valid |
| event_end | input | 1 | One-cycle pulse closing the current event |
| out_valid | output | 1 | A tuple is presented |
| out_ready | input | 1 | The consumer takes the tuple |
| out_dx | output | XW+1 | Signed row step |
| out_dy | output | YW+1 | Signed column step |
| out_adc | output | ADCW | Amplitude of the hit |
| ovf_err | output | 1 | Sticky: a hit was lost to a full row queue |

## Verification
The assertions assume that the consumer may hold `out_ready` low for any number of cycles. They also assume that `hit_row` never addresses a row at or above NROW, so every stored hit has a row queue to go to. The stimulus draws rows only from 0 to NROW−1 and stalls the output at random, about one cycle in four. It offers hits only between events, and it also offers them on purpose while the block is busy. Extra `event_end` pulses are sent only at moments when the block should ignore them.

// File: rtl/rowdelta_pkg.sv
package rowdelta_pkg;
  typedef enum logic [1:0] {
    PH_COLLECT = 2'd0,
    PH_SPREAD  = 2'd1,
    PH_DRAIN   = 2'd2
  } phase_e;
endpackage

// File: rtl/hit_fifo.sv
module hit_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    mem [DEPTH];
  logic [PW-1:0]   wp, rp;
  logic [CNTW-1:0] cnt;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      cnt <= cnt + CNTW'(push) - CNTW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  assign dout  = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == CNTW'(DEPTH));
endmodule

// File: rtl/rowdelta_ctrl.sv
module rowdelta_ctrl
  import rowdelta_pkg::*;
#(
  parameter int NCOL = 4,
  parameter int NROW = 8,
  localparam int XW  = (NROW > 1) ? $clog2(NROW) : 1,
  localparam int YW  = (NCOL > 1) ? $clog2(NCOL) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            event_end,
  input  logic [NCOL-1:0] col_empty,
  input  logic [NROW-1:0] row_empty,
  input  logic            out_valid,
  input  logic            out_ready,
  input  logic            ovf_hit,
  output logic            collecting,
  output logic [YW-1:0]   col_sel,
  output logic [XW-1:0]   row_sel,
  output logic            spread_move,
  output logic            take,
  output logic            ev_start,
  output logic            ovf_err
);
  phase_e phase;
  logic   any_row;

  assign collecting  = (phase == PH_COLLECT);
  assign ev_start    = collecting && event_end;
  assign spread_move = (phase == PH_SPREAD) && !col_empty[col_sel];
  assign any_row     = (row_empty != '1);
  assign take        = (phase == PH_DRAIN) && any_row && (!out_valid || out_ready);

  // lowest non-empty row queue wins
  always_comb begin
    row_sel = '0;
    for (int r = NROW - 1; r >= 0; r--) begin
      if (!row_empty[r]) row_sel = XW'(r);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_COLLECT;
      col_sel <= '0;
      ovf_err <= 1'b0;
    end else begin
      if (ovf_hit) ovf_err <= 1'b1;
      unique case (phase)
        PH_COLLECT: if (event_end) begin
          phase   <= PH_SPREAD;
          col_sel <= '0;
        end
        PH_SPREAD: if (col_empty[col_sel]) begin
          if (col_sel == YW'(NCOL - 1)) phase <= PH_DRAIN;
          else                          col_sel <= col_sel + 1'b1;
        end
        PH_DRAIN: if (!any_row && !out_valid) phase <= PH_COLLECT;
        default: phase <= PH_COLLECT;
      endcase
    end
  end
endmodule

// File: rtl/rowdelta_emit.sv
module rowdelta_emit #(
  parameter int XW   = 3,
  parameter int YW   = 2,
  parameter int ADCW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_start,
  input  logic            take,
  input  logic [XW-1:0]   in_x,
  input  logic [YW-1:0]   in_y,
  input  logic [ADCW-1:0] in_adc,
  input  logic            out_ready,
  output logic            out_valid,
  output logic [XW:0]     out_dx,
  output logic [YW:0]     out_dy,
  output logic [ADCW-1:0] out_adc
);
  logic [XW-1:0] ref_x;
  logic [YW-1:0] ref_y;

  // two's complement step, one bit wider than the coordinate
  function automatic logic [XW:0] step_x(input logic [XW-1:0] cur, input logic [XW-1:0] prv);
    return {1'b0, cur} - {1'b0, prv};
  endfunction

  function automatic logic [YW:0] step_y(input logic [YW-1:0] cur, input logic [YW-1:0] prv);
    return {1'b0, cur} - {1'b0, prv};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_x     <= '0;
      ref_y     <= '0;
      out_valid <= 1'b0;
      out_dx    <= '0;
      out_dy    <= '0;
      out_adc   <= '0;
    end else begin
      if (ev_start) begin
        ref_x <= '0;
        ref_y <= '0;
      end
      if (take) begin
        out_dx    <= step_x(in_x, ref_x);
        out_dy    <= step_y(in_y, ref_y);
        out_adc   <= in_adc;
        ref_x     <= in_x;
        ref_y     <= in_y;
        out_valid <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rowdelta_encoder.sv
module rowdelta_encoder #(
  parameter int NCOL   = 4,
  parameter int NROW   = 8,
  parameter int ADCW   = 5,
  parameter int CDEPTH = 4,
  parameter int RDEPTH = 4,
  localparam int XW    = (NROW > 1) ? $clog2(NROW) : 1,
  localparam int YW    = (NCOL > 1) ? $clog2(NCOL) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hit_valid,
  input  logic [YW-1:0]   hit_col,
  input  logic [XW-1:0]   hit_row,
  input  logic [ADCW-1:0] hit_adc,
  output logic            hit_ready,
  input  logic            event_end,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XW:0]     out_dx,
  output logic [YW:0]     out_dy,
  output logic [ADCW-1:0] out_adc,
  output logic            ovf_err
);
  localparam int CEW = XW + ADCW;
  localparam int REW = YW + ADCW;

  logic [NCOL-1:0] col_push, col_pop, col_empty, col_full;
  logic [NROW-1:0] row_push, row_pop, row_empty, row_full;
  logic [CEW-1:0]  col_dout [NCOL];
  logic [REW-1:0]  row_dout [NROW];

  logic            collecting, spread_move, take, ev_start, ovf_hit;
  logic [YW-1:0]   col_sel;
  logic [XW-1:0]   row_sel;
  logic [CEW-1:0]  col_head;
  logic [XW-1:0]   head_row;
  logic [ADCW-1:0] head_adc;
  logic [REW-1:0]  row_head;

  assign hit_ready = collecting && !col_full[hit_col];
  assign col_head  = col_dout[col_sel];
  assign head_row  = col_head[CEW-1:ADCW];
  assign head_adc  = col_head[ADCW-1:0];
  assign ovf_hit   = spread_move && row_full[head_row];
  assign row_head  = row_dout[row_sel];

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    assign col_push[c] = hit_valid && hit_ready && (hit_col == YW'(c));
    assign col_pop[c]  = spread_move && (col_sel == YW'(c));
    hit_fifo #(.W(CEW), .DEPTH(CDEPTH)) u_colq (
      .clk(clk), .rst_n(rst_n),
      .push(col_push[c]), .pop(col_pop[c]),
      .din({hit_row, hit_adc}), .dout(col_dout[c]),
      .empty(col_empty[c]), .full(col_full[c])
    );
  end

  for (genvar r = 0; r < NROW; r++) begin : g_row
    assign row_push[r] = spread_move && (head_row == XW'(r)) && !row_full[r];
    assign row_pop[r]  = take && (row_sel == XW'(r));
    hit_fifo #(.W(REW), .DEPTH(RDEPTH)) u_rowq (
      .clk(clk), .rst_n(rst_n),
      .push(row_push[r]), .pop(row_pop[r]),
      .din({col_sel, head_adc}), .dout(row_dout[r]),
      .empty(row_empty[r]), .full(row_full[r])
    );
  end

  rowdelta_ctrl #(.NCOL(NCOL), .NROW(NROW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .event_end(event_end),
    .col_empty(col_empty), .row_empty(row_empty),
    .out_valid(out_valid), .out_ready(out_ready), .ovf_hit(ovf_hit),
    .collecting(collecting), .col_sel(col_sel), .row_sel(row_sel),
    .spread_move(spread_move), .take(take), .ev_start(ev_start),
    .ovf_err(ovf_err)
  );

  rowdelta_emit #(.XW(XW), .YW(YW), .ADCW(ADCW)) u_emit (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .take(take),
    .in_x(row_sel), .in_y(row_head[REW-1:ADCW]), .in_adc(row_head[ADCW-1:0]),
    .out_ready(out_ready), .out_valid(out_valid),
    .out_dx(out_dx), .out_dy(out_dy), .out_adc(out_adc)
  );
endmodule

// File: rtl/rowdelta_encoder_chk.sv
module rowdelta_encoder_chk #(
  parameter int NCOL = 4,
  parameter int NROW = 8,
  parameter int XW   = 3,
  parameter int YW   = 2,
  parameter int ADCW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hit_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XW:0]     out_dx,
  input logic [YW:0]     out_dy,
  input logic [ADCW-1:0] out_adc,
  input logic            ovf_err,
  input logic [NCOL-1:0] col_pop,
  input logic [NROW-1:0] row_pop,
  input logic            spread_move
);
  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_dx) && $stable(out_dy) && $stable(out_adc));

  // R8
  no_out_while_collect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !hit_ready);

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

  // R3
  single_row_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_pop));

  // R8
  drain_after_spread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|row_pop) |-> !spread_move && (col_pop == '0));

  // R2
  no_accept_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spread_move |-> !hit_ready);
endmodule

bind rowdelta_encoder rowdelta_encoder_chk #(
  .NCOL(NCOL), .NROW(NROW), .XW(XW), .YW(YW), .ADCW(ADCW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hit_ready(hit_ready),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_dx(out_dx), .out_dy(out_dy), .out_adc(out_adc),
  .ovf_err(ovf_err), .col_pop(col_pop), .row_pop(row_pop),
  .spread_move(spread_move)
);

// File: tb/rowdelta_encoder_tb.sv
module rowdelta_encoder_tb;
  localparam int NCOL = 4, NROW = 8, ADCW = 5, CDEPTH = 4, RDEPTH = 4;
  localparam int XW = 3, YW = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            hit_valid = 1'b0;
  logic [YW-1:0]   hit_col = '0;
  logic [XW-1:0]   hit_row = '0;
  logic [ADCW-1:0] hit_adc = '0;
  logic            hit_ready;
  logic            event_end = 1'b0;
  logic            out_valid;
  logic            out_ready = 1'b0;
  logic [XW:0]     out_dx;
  logic [YW:0]     out_dy;
  logic [ADCW-1:0] out_adc;
  logic            ovf_err;

  always #5 clk = ~clk;

  rowdelta_encoder #(.NCOL(NCOL), .NROW(NROW), .ADCW(ADCW), .CDEPTH(CDEPTH), .RDEPTH(RDEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_col(hit_col),
    .hit_row(hit_row), .hit_adc(hit_adc), .hit_ready(hit_ready),
    .event_end(event_end), .out_valid(out_valid), .out_ready(out_ready),
    .out_dx(out_dx), .out_dy(out_dy), .out_adc(out_adc), .ovf_err(ovf_err)
  );

  typedef struct { int r; int c; int a; int dx; int dy; bit first; } hit_t;

  hit_t colq [NCOL][$];
  hit_t expq [$];
  int   n_chk = 0, n_fail = 0;
  bit   sticky_ovf = 1'b0;
  bit   run_cons = 1'b0;
  bit   held = 1'b0;
  logic [XW:0]     h_dx;
  logic [YW:0]     h_dy;
  logic [ADCW-1:0] h_adc;

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // signed step as the consumer sees it
  function automatic int sx(logic [XW:0] v);
    return int'($signed(v));
  endfunction
  function automatic int sy(logic [YW:0] v);
    return int'($signed(v));
  endfunction

  // consumer: random stalls, compares each accepted tuple
  always @(negedge clk) begin
    if (run_cons) begin
      bit rdy;
      hit_t e;
      rdy = ($urandom % 4) != 0;
      if (held) begin
        check("R6", "valid held", int'(out_valid), 1);
        check("R6", "dx held", int'(out_dx), int'(h_dx));
        check("R6", "dy held", int'(out_dy), int'(h_dy));
        check("R6", "adc held", int'(out_adc), int'(h_adc));
      end
      if (out_valid) check("R8", "tuple during collect", int'(hit_ready), 0);
      held  = out_valid && !rdy;
      h_dx  = out_dx;
      h_dy  = out_dy;
      h_adc = out_adc;
      out_ready = rdy;
      if (out_valid && rdy) begin
        if (expq.size() == 0) begin
          check("R2", "unexpected tuple count", 1, 0);
        end else begin
          e = expq.pop_front();
          if (e.first) begin
            check("R5", "first dx", sx(out_dx), e.dx);
            check("R5", "first dy", sy(out_dy), e.dy);
          end else begin
            check("R4", "dx", sx(out_dx), e.dx);
            check("R4", "dy", sy(out_dy), e.dy);
          end
          check("R3", "adc in order", int'(out_adc), e.a);
        end
      end
    end
  end

  task automatic put_hit(int c, int r, int a);
    hit_t h;
    bit acc, want;
    @(negedge clk);
    hit_valid = 1'b1;
    hit_col = YW'(c);
    hit_row = XW'(r);
    hit_adc = ADCW'(a);
    #1;
    acc  = hit_ready;
    want = colq[c].size() < CDEPTH;
    check("R2", "hit accepted", int'(acc), int'(want));
    h.r = r; h.c = c; h.a = a; h.dx = 0; h.dy = 0; h.first = 1'b0;
    if (acc) colq[c].push_back(h);
    @(posedge clk);
    #1 hit_valid = 1'b0;
    hit_col = '0;
  endtask

  task automatic close_event(bit extra_end, bit poke_busy);
    hit_t rowl [NROW][$];
    int px, py, guard;
    bit first;
    // R7 model: column-by-column copy with finite row queues
    for (int c = 0; c < NCOL; c++) begin
      for (int i = 0; i < colq[c].size(); i++) begin
        if (rowl[colq[c][i].r].size() < RDEPTH) rowl[colq[c][i].r].push_back(colq[c][i]);
        else sticky_ovf = 1'b1;
      end
      colq[c].delete();
    end
    px = 0; py = 0; first = 1'b1;
    for (int r = 0; r < NROW; r++) begin
      for (int i = 0; i < rowl[r].size(); i++) begin
        hit_t h;
        h = rowl[r][i];
        h.dx = h.r - px;
        h.dy = h.c - py;
        h.first = first;
        first = 1'b0;
        px = h.r; py = h.c;
        expq.push_back(h);
      end
    end
    @(negedge clk);
    event_end = 1'b1;
    @(posedge clk);
    #1 event_end = 1'b0;
    check("R2", "busy after event end", int'(hit_ready), 0);
    if (extra_end) begin
      @(negedge clk);
      event_end = 1'b1;
      @(posedge clk);
      #1 event_end = 1'b0;
    end
    if (poke_busy) begin
      // R2: hit offered while busy must be lost
      @(negedge clk);
      hit_valid = 1'b1;
      hit_col = 2'd1;
      hit_row = 3'd6;
      hit_adc = 5'd17;
      #1 check("R2", "ready while busy", int'(hit_ready), 0);
      @(posedge clk);
      #1 hit_valid = 1'b0;
      hit_col = '0;
    end
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!hit_ready && guard < 3000);
    check("R8", "returned to collect", int'(hit_ready), 1);
    check("R3", "tuples left over", expq.size(), 0);
    check("R7", "overflow flag", int'(ovf_err), int'(sticky_ovf));
    if (extra_end) begin
      // R9: the second pulse must not have opened another event
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        check("R9", "stays collecting", int'(hit_ready), 1);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", "out_valid after reset", int'(out_valid), 0);
    check("R1", "hit_ready after reset", int'(hit_ready), 1);
    check("R1", "ovf_err after reset", int'(ovf_err), 0);
    run_cons = 1'b1;

    // column-grouped hits reordered by row then column (R3, R5)
    put_hit(0, 1, 7);
    put_hit(0, 3, 9);
    put_hit(2, 3, 4);
    put_hit(1, 0, 21);
    close_event(1'b0, 1'b0);

    // reference reset, late event_end ignored, busy hit dropped (R5, R9, R2)
    put_hit(3, 7, 31);
    put_hit(3, 0, 0);
    put_hit(1, 7, 12);
    close_event(1'b1, 1'b1);

    // widest negative column step and large row step (R4)
    put_hit(3, 0, 1);
    put_hit(0, 1, 2);
    put_hit(0, 7, 3);
    close_event(1'b0, 1'b0);

    // full column refuses the fifth hit (R2)
    for (int i = 0; i < 5; i++) put_hit(3, 5, i + 10);
    close_event(1'b0, 1'b0);

    // event without hits (R8)
    close_event(1'b0, 1'b0);

    // random events, duplicates and occasional row overflow
    for (int ev = 0; ev < 40; ev++) begin
      int n;
      n = $urandom_range(0, 16);
      for (int i = 0; i < n; i++)
        put_hit($urandom_range(0, NCOL - 1), $urandom_range(0, NROW - 1), $urandom_range(0, 31));
      close_event(1'b0, 1'b0);
    end

    // row 2 receives five hits: the last one copied is dropped (R7)
    put_hit(0, 2, 1);
    put_hit(0, 2, 2);
    put_hit(1, 2, 3);
    put_hit(1, 2, 4);
    put_hit(2, 2, 5);
    put_hit(3, 6, 6);
    close_event(1'b0, 1'b0);
    check("R7", "flag after overflow", int'(ovf_err), 1);

    put_hit(2, 4, 8);
    close_event(1'b0, 1'b0);
    check("R7", "flag still set", int'(ovf_err), 1);

    run_cons = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule